// File: doc/BRIEF.md
# Serial Transmitter with Break Generation

This block serialises bytes onto a single asynchronous line. Each byte goes out as a low start bit, eight data bits beginning with bit 0, an optional parity bit and a high stop bit. Every bit lasts exactly one interval between baud-tick enables. A one-entry holding slot accepts a byte whenever the ready flag is high. The shifter takes bytes from that slot on bit boundaries, so a steady writer gets back-to-back frames.

Two command pulses control a line break. The break is scheduled like a character: it takes the holding slot, waits for any frame already in flight to finish, then drives the line low for at least one full frame time. It ends only after a stop command has been seen and that minimum has passed. A high recovery interval then follows, lasting twelve bit times or the programmed guard length, whichever is larger. Commands that arrive at the wrong moment are dropped, and so are bytes written while a break is waiting to start.

Top module: `brk_uart_tx`

## Requirements
- R1: After reset the line is high and both ready and empty are 1. A frame is one low start bit, 8 data bits least significant first, a parity bit only when par_mode is 2'b01 (even: the parity bit makes the count of ones even) or 2'b10 (odd), and one high stop bit. par_mode 2'b00 and 2'b11 send no parity bit. Each bit holds for one baud_tick interval.
- R2: A write is taken only while ready is 1. A taken write drops ready and empty on the next cycle. Ready comes back once the shifter has taken the byte, so a second byte written then follows with no idle bit between the frames.
- R3: A break start accepted while a frame is shifting out lets that frame finish, including its stop bit, before the line goes low.
- R4: The line stays low for at least one frame length: 10 bit times without parity, 11 with parity. A stop command that arrives earlier ends the break exactly at that minimum.
- R5: A stop command that arrives after the minimum ends the break at the next bit boundary.
- R6: Break commands are accepted only while ready is 1. An accepted start drops ready and empty on the next cycle.
- R7: A start command is ignored while a break is pending, active or in its recovery interval.
- R8: A stop command with no break in progress has no effect: the line stays high and ready and empty stay 1.
- R9: A cycle in which start and stop are both asserted is ignored.
- R10: A byte written while a break is pending but not yet started is dropped and never sent. This includes a byte written in the same cycle as an accepted start.
- R11: After a break, the line stays high for max(12, guard_len) bit times, and empty stays 0 until that interval is over. A byte waiting in the holding slot starts right at the end of the interval.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| baud_tick | input | 1 | One-cycle enable marking each bit boundary |
| wr_valid | input | 1 | Byte write strobe |
| wr_data | input | 8 | Byte to send |
| brk_start | input | 1 | Break start command pulse |
| brk_stop | input | 1 | Break stop command pulse |
| par_mode | input | 2 | Parity select (00 none, 01 even, 10 odd, 11 none) |
| guard_len | input | 8 | Post-break high time in bit times (floor of 12) |
| tx | output | 1 | Serial line |
| rdy | output | 1 | Holding slot free |
| empty | output | 1 | Nothing queued, shifting, breaking or recovering |

## Verification
On every cycle, the assertions check the following: start commands are dropped during a break, and simultaneous commands are dropped. Writes are discarded while a break is pending, and a latched stop only exists inside a break. The break cannot leave before its minimum, recovery cannot end before twelve bit times, and empty implies a high line. Other properties need whole-frame context, so only the scoreboard scenarios show them. These are the bit order and parity values on the line, and the exact break length for early and late stops. They also include the frame finishing before a break, the exact recovery gap before a queued byte, and the absence of any frame for a dropped byte.

// File: rtl/brk_uart_pkg.sv
package brk_uart_pkg;

    typedef enum logic [1:0] {
        PAR_NONE = 2'd0,
        PAR_EVEN = 2'd1,
        PAR_ODD  = 2'd2,
        PAR_OFF  = 2'd3
    } par_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_START,
        S_DATA,
        S_PAR,
        S_STOP,
        S_BRK,
        S_RECOV
    } tx_st_e;

    typedef struct packed {
        logic en;
        logic val;
    } par_bit_t;

    function automatic logic par_enabled(input logic [1:0] mode);
        return (mode == PAR_EVEN) || (mode == PAR_ODD);
    endfunction

    function automatic int unsigned frame_bits(input int unsigned dw, input logic [1:0] mode);
        return dw + 32'd2 + (par_enabled(mode) ? 32'd1 : 32'd0);
    endfunction

    function automatic logic calc_par(input logic odd, input logic [31:0] d);
        return odd ^ (^d);
    endfunction

endpackage

// File: rtl/brk_tx_slot.sv
module brk_tx_slot
    import brk_uart_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_valid,
    input  logic [DW-1:0] wr_data,
    input  logic          cmd_start,
    input  logic          cmd_stop,
    input  logic          brk_busy,
    input  logic          in_brk,
    input  logic          take_char,
    input  logic          take_brk,
    output logic          hold_full,
    output logic [DW-1:0] hold_data,
    output logic          brk_pend,
    output logic          rdy,
    output logic          stop_acc
);

    logic start_acc;
    logic wr_acc;

    assign rdy       = !hold_full && !brk_pend;
    assign start_acc = rdy && cmd_start && !cmd_stop && !brk_busy;
    assign stop_acc  = rdy && cmd_stop && !cmd_start && in_brk;
    assign wr_acc    = wr_valid && rdy && !start_acc;

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_full <= 1'b0;
            hold_data <= '0;
            brk_pend  <= 1'b0;
        end else begin
            if (start_acc) begin
                brk_pend <= 1'b1;
            end else if (take_brk) begin
                brk_pend <= 1'b0;
            end
            if (wr_acc) begin
                hold_full <= 1'b1;
                hold_data <= wr_data;
            end else if (take_char) begin
                hold_full <= 1'b0;
            end
        end
    end

    AST_START_BLOCKED_IN_BRK: assert property (@(posedge clk) disable iff (rst)
        (brk_busy && cmd_start && !brk_pend) |=> !brk_pend); // R7

    AST_BOTH_CMDS_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (cmd_start && cmd_stop && !brk_pend) |=> !brk_pend); // R9

    AST_START_DROPS_RDY: assert property (@(posedge clk) disable iff (rst)
        start_acc |=> !rdy); // R6

    AST_PEND_WRITE_DROPPED: assert property (@(posedge clk) disable iff (rst)
        (brk_pend && !hold_full && wr_valid) |=> !hold_full); // R10

endmodule

// File: rtl/brk_tx_engine.sv
module brk_tx_engine
    import brk_uart_pkg::*;
#(
    parameter int DW        = 8,
    parameter int GW        = 8,
    parameter int RECOV_MIN = 12
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tick,
    input  logic [1:0]    par_mode,
    input  logic [GW-1:0] guard_len,
    input  logic          hold_full,
    input  logic [DW-1:0] hold_data,
    input  logic          brk_pend,
    input  logic          stop_acc,
    output logic          take_char,
    output logic          take_brk,
    output logic          tx,
    output logic          brk_busy,
    output logic          in_brk,
    output logic          idle
);

    localparam int BW    = (DW > 1) ? $clog2(DW) : 1;
    localparam int FMAX  = DW + 3;
    localparam int AW    = (GW > $clog2(FMAX + 1)) ? GW : $clog2(FMAX + 1);
    localparam int BASEW = (AW > $clog2(RECOV_MIN + 1)) ? AW : $clog2(RECOV_MIN + 1);
    localparam int CW    = BASEW + 1;

    tx_st_e         st;
    logic [DW-1:0]  sh;
    logic [BW-1:0]  bidx;
    par_bit_t       pq;
    logic [CW-1:0]  cnt;
    logic [CW-1:0]  flen;
    logic [CW-1:0]  rlen;
    logic           stop_q;
    logic           slot_end;
    logic           recov_done;
    logic           brk_done;

    assign rlen       = (CW'(guard_len) > CW'(RECOV_MIN)) ? CW'(guard_len) : CW'(RECOV_MIN);
    assign recov_done = (st == S_RECOV) && (cnt == rlen - CW'(1));
    assign brk_done   = stop_q && (cnt >= flen - CW'(1));
    assign slot_end   = tick && ((st == S_IDLE) || (st == S_STOP) || recov_done);
    assign take_char  = slot_end && hold_full;
    assign take_brk   = slot_end && !hold_full && brk_pend;

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= S_IDLE;
            sh     <= '0;
            bidx   <= '0;
            pq     <= '0;
            cnt    <= '0;
            flen   <= '0;
            stop_q <= 1'b0;
        end else begin
            if (stop_acc) begin
                stop_q <= 1'b1;
            end
            if (tick) begin
                case (st)
                    S_START: begin
                        st   <= S_DATA;
                        bidx <= '0;
                    end
                    S_DATA: begin
                        sh <= sh >> 1;
                        if (bidx == BW'(DW - 1)) begin
                            st <= pq.en ? S_PAR : S_STOP;
                        end else begin
                            bidx <= bidx + BW'(1);
                        end
                    end
                    S_PAR: st <= S_STOP;
                    S_BRK: begin
                        if (brk_done) begin
                            st     <= S_RECOV;
                            cnt    <= '0;
                            stop_q <= 1'b0;
                        end else if (cnt != '1) begin
                            cnt <= cnt + CW'(1);
                        end
                    end
                    S_RECOV: begin
                        if (!recov_done) begin
                            cnt <= cnt + CW'(1);
                        end
                    end
                    default: ;
                endcase
                if (take_char) begin
                    st <= S_START;
                    sh <= hold_data;
                    pq <= '{en: par_enabled(par_mode),
                            val: calc_par(par_mode == PAR_ODD, 32'(hold_data))};
                end else if (take_brk) begin
                    st     <= S_BRK;
                    cnt    <= '0;
                    stop_q <= 1'b0;
                    flen   <= CW'(frame_bits(DW, par_mode));
                end else if (slot_end) begin
                    st <= S_IDLE;
                end
            end
        end
    end

    always_comb begin
        case (st)
            S_START: tx = 1'b0;
            S_DATA:  tx = sh[0];
            S_PAR:   tx = pq.val;
            S_BRK:   tx = 1'b0;
            default: tx = 1'b1;
        endcase
    end

    assign brk_busy = (st == S_BRK) || (st == S_RECOV);
    assign in_brk   = (st == S_BRK);
    assign idle     = (st == S_IDLE);

    AST_STOP_ONLY_IN_BRK: assert property (@(posedge clk) disable iff (rst)
        stop_q |-> (st == S_BRK)); // R8

    AST_BRK_MIN_HELD: assert property (@(posedge clk) disable iff (rst)
        ((st == S_BRK) && tick && (cnt < flen - CW'(1))) |=> (st == S_BRK)); // R4

    AST_RECOV_FLOOR: assert property (@(posedge clk) disable iff (rst)
        ((st == S_RECOV) && tick && (cnt < CW'(RECOV_MIN - 1))) |=> (st == S_RECOV)); // R11

endmodule

// File: rtl/brk_uart_tx.sv
module brk_uart_tx
    import brk_uart_pkg::*;
#(
    parameter int DW        = 8,
    parameter int GW        = 8,
    parameter int RECOV_MIN = 12
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          baud_tick,
    input  logic          wr_valid,
    input  logic [DW-1:0] wr_data,
    input  logic          brk_start,
    input  logic          brk_stop,
    input  logic [1:0]    par_mode,
    input  logic [GW-1:0] guard_len,
    output logic          tx,
    output logic          rdy,
    output logic          empty
);

    logic          hold_full;
    logic [DW-1:0] hold_data;
    logic          brk_pend;
    logic          stop_acc;
    logic          take_char;
    logic          take_brk;
    logic          brk_busy;
    logic          in_brk;
    logic          idle;

    brk_tx_slot #(.DW(DW)) u_slot (
        .clk       (clk),
        .rst       (rst),
        .wr_valid  (wr_valid),
        .wr_data   (wr_data),
        .cmd_start (brk_start),
        .cmd_stop  (brk_stop),
        .brk_busy  (brk_busy),
        .in_brk    (in_brk),
        .take_char (take_char),
        .take_brk  (take_brk),
        .hold_full (hold_full),
        .hold_data (hold_data),
        .brk_pend  (brk_pend),
        .rdy       (rdy),
        .stop_acc  (stop_acc)
    );

    brk_tx_engine #(.DW(DW), .GW(GW), .RECOV_MIN(RECOV_MIN)) u_engine (
        .clk       (clk),
        .rst       (rst),
        .tick      (baud_tick),
        .par_mode  (par_mode),
        .guard_len (guard_len),
        .hold_full (hold_full),
        .hold_data (hold_data),
        .brk_pend  (brk_pend),
        .stop_acc  (stop_acc),
        .take_char (take_char),
        .take_brk  (take_brk),
        .tx        (tx),
        .brk_busy  (brk_busy),
        .in_brk    (in_brk),
        .idle      (idle)
    );

    assign empty = idle && !hold_full && !brk_pend;

    AST_EMPTY_LINE_HIGH: assert property (@(posedge clk) disable iff (rst)
        empty |-> tx); // R11

endmodule

// File: tb/brk_uart_tx_tb.sv
`timescale 1ns/1ps
module brk_uart_tx_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       baud_tick = 1'b0;
    logic       wr_valid = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       brk_start = 1'b0;
    logic       brk_stop = 1'b0;
    logic [1:0] par_mode = 2'b00;
    logic [7:0] guard_len = 8'd0;
    logic       tx, rdy, empty;

    always #2.5 clk = ~clk;

    brk_uart_tx u_dut (
        .clk(clk), .rst(rst), .baud_tick(baud_tick), .wr_valid(wr_valid),
        .wr_data(wr_data), .brk_start(brk_start), .brk_stop(brk_stop),
        .par_mode(par_mode), .guard_len(guard_len), .tx(tx), .rdy(rdy), .empty(empty)
    );

    int tcnt = 0;
    always @(posedge clk) begin
        tcnt      <= (tcnt == 3) ? 0 : tcnt + 1;
        baud_tick <= (tcnt == 3);
    end

    typedef struct {
        bit         is_brk;
        logic [7:0] data;
        logic [1:0] par;
        int         bmin;
        int         bmax;
        int         gmin;
        int         gmax;
        string      tag;
    } exp_t;

    exp_t sb[$];
    int   n_chk = 0;
    int   n_fail = 0;
    int   mon_mode = 0;
    bit   done = 0;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    // monitor: decodes the line at mid-bit and pops the scoreboard
    initial begin
        int mode = 0;
        int idx = 0;
        int flen = 10;
        int lowcnt = 0;
        int gapcnt = 0;
        int gneed = 0;
        int gmax = 0;
        logic [10:0] bits = '0;
        logic [1:0]  fpar = 2'b00;
        logic        pexp;
        exp_t e;
        forever begin
            @(negedge clk);
            if (baud_tick && !rst) begin
                @(negedge clk);
                case (mode)
                    0, 3: begin
                        if (tx == 1'b0) begin
                            if (mode == 3) begin
                                check(gapcnt >= gneed, "R11 recovery gap min", gapcnt, gneed);
                                check(gapcnt <= gmax, "R11 recovery gap max", gapcnt, gmax);
                            end
                            mode = 1;
                            idx  = 0;
                            fpar = par_mode;
                            flen = 10 + (((fpar == 2'b01) || (fpar == 2'b10)) ? 1 : 0);
                            bits = '0;
                        end else if (mode == 3) begin
                            gapcnt++;
                        end
                    end
                    1: begin
                        bits[idx] = tx;
                        idx++;
                        if (idx == flen - 1) begin
                            if (bits == '0) begin
                                mode   = 2;
                                lowcnt = flen;
                            end else begin
                                mode = 0;
                                if (sb.size() == 0) begin
                                    check(1'b0, "R1 unexpected frame", int'(bits[7:0]), -1);
                                end else begin
                                    e = sb.pop_front();
                                    check(!e.is_brk, {e.tag, " kind"}, 0, 1);
                                    check(bits[7:0] == e.data, {e.tag, " data"}, int'(bits[7:0]), int'(e.data));
                                    if (flen == 11) begin
                                        pexp = (e.par == 2'b10) ^ (^e.data);
                                        check(bits[8] == pexp, {e.tag, " parity R1"}, int'(bits[8]), int'(pexp));
                                    end
                                    check(bits[flen-2] == 1'b1, {e.tag, " stop R1"}, int'(bits[flen-2]), 1);
                                end
                            end
                        end
                    end
                    default: begin
                        if (tx == 1'b0) begin
                            lowcnt++;
                        end else begin
                            if (sb.size() == 0) begin
                                check(1'b0, "R7 unexpected break", lowcnt, 0);
                                gneed = 0;
                                gmax  = 1000000;
                            end else begin
                                e = sb.pop_front();
                                check(e.is_brk, {e.tag, " kind"}, 0, 1);
                                check(lowcnt >= e.bmin, {e.tag, " break min"}, lowcnt, e.bmin);
                                check(lowcnt <= e.bmax, {e.tag, " break max"}, lowcnt, e.bmax);
                                gneed = e.gmin;
                                gmax  = e.gmax;
                            end
                            gapcnt = 1;
                            mode   = 3;
                        end
                    end
                endcase
                mon_mode = mode;
            end
        end
    end

    task automatic wait_ticks(input int n);
        repeat (n) begin
            do @(negedge clk); while (!baud_tick);
        end
    endtask

    task automatic send(input logic [7:0] d, input string tag);
        while (!rdy) @(negedge clk);
        wr_valid = 1'b1;
        wr_data  = d;
        sb.push_back('{is_brk: 1'b0, data: d, par: par_mode, bmin: 0, bmax: 0,
                       gmin: 0, gmax: 0, tag: tag});
        @(negedge clk);
        wr_valid = 1'b0;
        check(rdy == 1'b0, "R2 ready dropped after write", int'(rdy), 0);
        check(empty == 1'b0, "R2 empty dropped after write", int'(empty), 0);
    endtask

    task automatic start_brk(input int bmin, input int bmax, input int gmin, input int gmax,
                             input string tag);
        while (!rdy) @(negedge clk);
        brk_start = 1'b1;
        sb.push_back('{is_brk: 1'b1, data: 8'h00, par: par_mode, bmin: bmin, bmax: bmax,
                       gmin: gmin, gmax: gmax, tag: tag});
        @(negedge clk);
        brk_start = 1'b0;
        check(rdy == 1'b0, "R6 ready dropped by start", int'(rdy), 0);
        check(empty == 1'b0, "R6 empty dropped by start", int'(empty), 0);
    endtask

    task automatic pulse_stop();
        brk_stop = 1'b1;
        @(negedge clk);
        brk_stop = 1'b0;
    endtask

    task automatic wait_idle();
        do @(negedge clk); while (!(empty && (sb.size() == 0) && (mon_mode != 1) && (mon_mode != 2)));
        wait_ticks(2);
    endtask

    initial begin
        int cnt;
        repeat (5) @(negedge clk);
        check(tx == 1'b1, "R1 reset line high", int'(tx), 1);
        check(rdy == 1'b1, "R1 reset ready", int'(rdy), 1);
        check(empty == 1'b1, "R1 reset empty", int'(empty), 1);
        rst = 1'b0;
        wait_ticks(2);

        // frames without parity, back to back
        send(8'hA5, "R1 plain A5");
        send(8'h3C, "R2 back-to-back 3C");
        wait_idle();

        // even then odd parity
        par_mode = 2'b01;
        send(8'h01, "R1 even 01");
        send(8'h7F, "R1 even 7F");
        wait_idle();
        par_mode = 2'b10;
        send(8'h00, "R1 odd 00");
        send(8'hFF, "R1 odd FF");
        wait_idle();
        par_mode = 2'b00;

        // R8: stop with no break
        pulse_stop();
        @(negedge clk);
        check(rdy == 1'b1, "R8 ready after lone stop", int'(rdy), 1);
        wait_ticks(14);
        check(tx == 1'b1, "R8 line high after lone stop", int'(tx), 1);
        check(empty == 1'b1, "R8 empty after lone stop", int'(empty), 1);

        // R9: both commands together
        brk_start = 1'b1;
        brk_stop  = 1'b1;
        @(negedge clk);
        brk_start = 1'b0;
        brk_stop  = 1'b0;
        check(rdy == 1'b1, "R9 ready after dual command", int'(rdy), 1);
        check(empty == 1'b1, "R9 empty after dual command", int'(empty), 1);
        wait_ticks(14);
        check(tx == 1'b1, "R9 line high after dual command", int'(tx), 1);

        // R4: break from idle, early stop, recovery floor of 12
        start_brk(10, 10, 12, 1000000, "R4 early stop break");
        while (!rdy) @(negedge clk);
        pulse_stop();
        while (tx != 1'b1) @(negedge clk);
        wait_ticks(3);
        check(empty == 1'b0, "R11 empty held in recovery", int'(empty), 0);
        cnt = 3;
        while (!empty) begin
            wait_ticks(1);
            cnt++;
        end
        check(cnt >= 12, "R11 empty returns after recovery", cnt, 12);
        wait_idle();

        // R3/R5/R7/R10: break queued behind a frame, long guard
        par_mode  = 2'b01;
        guard_len = 8'd20;
        send(8'h5A, "R3 frame before break");
        start_brk(18, 26, 20, 20, "R5 late stop break");
        wr_valid = 1'b1;
        wr_data  = 8'hEE;
        @(negedge clk);
        wr_valid = 1'b0;
        check(rdy == 1'b0, "R10 write refused while pending", int'(rdy), 0);
        while (!rdy) @(negedge clk);
        check(tx == 1'b0, "R3 line low once break starts", int'(tx), 0);
        brk_start = 1'b1;
        @(negedge clk);
        brk_start = 1'b0;
        @(negedge clk);
        check(rdy == 1'b1, "R7 second start ignored", int'(rdy), 1);
        wait_ticks(20);
        pulse_stop();
        while (tx != 1'b1) @(negedge clk);
        send(8'hC3, "R11 frame after guard");
        wait_idle();
        wait_ticks(30);
        check(sb.size() == 0, "R10 no dropped byte sent", sb.size(), 0);
        check(tx == 1'b1 && empty == 1'b1, "R11 final idle", int'(empty), 1);
        finish_run();
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
            finish_run();
        end
    end

endmodule